// File: doc/BRIEF.md
# Write-Protection Command Sequence Detector

This block sits between the host-side write strobe capture of a byte-wide nonvolatile memory and its page write engine. It watches every accepted byte write (address and data). It recognises two command patterns: a three-byte code that arms protection and also opens a protected write, and a six-byte code that removes protection. It holds the protection flag. Bytes that belong to a command are consumed and never reach the engine. Ordinary bytes are forwarded one cycle after their strobe, unless protection is on and the load period did not open with the three-byte code.

A load period starts with the first accepted strobe. It ends when no strobe arrives for `BLC_CYCLES` consecutive cycles. At that point the block decides whether a timed programming cycle of `WC_CYCLES` cycles runs. It runs when bytes were forwarded, when a command completed, or when the part is protected. In the protected case the timer runs even though no data changes. Any change to the protection flag takes effect in the cycle the programming cycle ends. Strobes that arrive while the cycle is running are ignored.

Top module: `wp_seq_guard`

## Requirements
- R1: After reset, `prot` equals the parameter `PROT_AT_RESET` (default 0, unprotected), and `busy`, `pass_vld` and `prog_start` are 0.
- R2: When unprotected, each ordinary accepted byte appears on `pass_addr`/`pass_data` with `pass_vld` high in the cycle after its strobe. `BLC_CYCLES` strobe-free cycles after the last byte, `prog_start` pulses for one cycle and `busy` stays high for exactly `WC_CYCLES` cycles.
- R3: The arming code is three bytes: data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. None of these bytes is forwarded. A programming cycle runs even if no data byte follows, and `prot` becomes 1 in the cycle `busy` falls.
- R4: The release code is six bytes, each data at address: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. None of these bytes is forwarded. Bytes that follow it in the same load period are forwarded, and `prot` becomes 0 when `busy` falls.
- R5: When protected, a load period that does not open with the arming code forwards no byte, yet still pulses `prog_start` and runs `busy` for `WC_CYCLES`. `prot` stays 1.
- R6: When protected, data bytes that follow the arming code in the same load period are forwarded, and `prot` stays 1.
- R7: A byte that breaks a partly matched code ends the match. The earlier code bytes stay consumed. The breaking byte and the rest of the load period are handled as an ordinary load: forwarded when unprotected, dropped when protected.
- R8: A gap of `BLC_CYCLES` cycles inside a code aborts it. When unprotected and nothing was forwarded, no programming cycle runs. The next byte starts a fresh load period.
- R9: Strobes while `busy` is high are ignored. They cause no forwarding, do not change `prot`, and do not change the length of the busy window.
- R10: The command addresses hold ordinary data. A byte of 0xAA at 0x5555 that is not the first byte of a load period is forwarded.
- R11: `prot` changes only in the cycle in which `busy` falls. A block built with `PROT_AT_RESET`=1 starts protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle pulse per captured byte write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Byte value of the write |
| pass_vld | output | 1 | A byte is forwarded to the page engine this cycle |
| pass_addr | output | ADDR_W | Address of the forwarded byte |
| pass_data | output | DATA_W | Value of the forwarded byte |
| prog_start | output | 1 | One-cycle pulse: a programming cycle begins |
| busy | output | 1 | Programming cycle in progress |
| prot | output | 1 | Protection flag |

## Verification
A matcher stuck in a partial-code state shows up at the first data byte after it: that byte goes missing from `pass_vld`, or a byte that should be dropped appears, one cycle after its strobe. A wrong pending flag or protection value stays hidden until the end of the busy window. There `prot` either fails to move or moves at the wrong moment. The next load period then shows it again, as bytes forwarded or dropped against expectation. A load-gap counter error shifts `prog_start` away from exactly `BLC_CYCLES` cycles after the last byte. A busy counter error changes the measured high time of `busy`.

// File: rtl/wp_pkg.sv
package wp_pkg;

    // Matching code table: index -> (address, data)
    localparam int NUM_CODES = 5;
    localparam int HIT_KEY1  = 0;   // 0xAA @ 0x5555
    localparam int HIT_KEY2  = 1;   // 0x55 @ 0x2AAA
    localparam int HIT_ARM   = 2;   // 0xA0 @ 0x5555
    localparam int HIT_OFF1  = 3;   // 0x80 @ 0x5555
    localparam int HIT_OFF2  = 4;   // 0x20 @ 0x5555

    localparam logic [14:0] CODE_ADDR [NUM_CODES] =
        '{15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h5555};
    localparam logic [7:0]  CODE_DATA [NUM_CODES] =
        '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h20};

    typedef enum logic [3:0] {
        SQ_IDLE,     // no byte yet in this load period
        SQ_K1,       // first key byte seen
        SQ_K2,       // second key byte seen
        SQ_R3,       // release step 3 seen
        SQ_R4,       // release step 4 seen
        SQ_R5,       // release step 5 seen
        SQ_OPEN,     // code complete, data bytes pass
        SQ_PLAIN,    // ordinary load, unprotected
        SQ_LOCKED    // ordinary load, protected: bytes dropped
    } seq_e;

    typedef enum logic [1:0] {
        PD_NONE,
        PD_SET,
        PD_CLR
    } pend_e;

endpackage

// File: rtl/wp_cmd_match.sv
module wp_cmd_match
    import wp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    data,
    output logic [NUM_CODES-1:0] hit
);

    for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
        assign hit[k] = (addr == ADDR_W'(CODE_ADDR[k])) &&
                        (data == DATA_W'(CODE_DATA[k]));
    end

endmodule

// File: rtl/wp_gap_timer.sv
module wp_gap_timer #(
    parameter int LIMIT = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic expire
);

    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } gap_t;

    gap_t st_q, st_d;

    assign expire = st_q.armed && !kick && (st_q.cnt == CW'(LIMIT - 1));

    always_comb begin
        st_d = st_q;
        if (kick) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (expire) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (st_q.armed) begin
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wp_busy_timer.sv
module wp_busy_timer #(
    parameter int LIMIT = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } bz_t;

    bz_t st_q, st_d;

    assign busy = st_q.busy;
    assign done = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(LIMIT - 1);
        end else if (done) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
    import wp_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int BLC_CYCLES    = 1500,
    parameter int WC_CYCLES     = 50000,
    parameter bit PROT_AT_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pass_vld,
    output logic [ADDR_W-1:0] pass_addr,
    output logic [DATA_W-1:0] pass_data,
    output logic              prog_start,
    output logic              busy,
    output logic              prot
);

    typedef struct packed {
        seq_e              seq;
        pend_e             pend;
        logic              passed;
        logic              prot;
        logic              pass_vld;
        logic [ADDR_W-1:0] pass_addr;
        logic [DATA_W-1:0] pass_data;
        logic              prog_start;
    } guard_t;

    guard_t st_q, st_d;

    logic [NUM_CODES-1:0] hit;
    logic                 take;
    logic                 gap_end;
    logic                 wc_busy;
    logic                 wc_done;
    logic                 to_plain;
    logic                 fwd;

    assign take = wr_stb && !wc_busy;

    wp_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_match (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (hit)
    );

    wp_gap_timer #(.LIMIT(BLC_CYCLES)) i_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick   (take),
        .expire (gap_end)
    );

    wp_busy_timer #(.LIMIT(WC_CYCLES)) i_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (st_d.prog_start),
        .busy  (wc_busy),
        .done  (wc_done)
    );

    always_comb begin
        st_d            = st_q;
        st_d.pass_vld   = 1'b0;
        st_d.prog_start = 1'b0;
        to_plain        = 1'b0;
        fwd             = 1'b0;

        // Apply a pending protection change as the programming cycle ends.
        if (wc_done) begin
            unique case (st_q.pend)
                PD_SET:  st_d.prot = 1'b1;
                PD_CLR:  st_d.prot = 1'b0;
                default: st_d.prot = st_q.prot;
            endcase
            st_d.pend = PD_NONE;
        end

        if (take) begin
            unique case (st_q.seq)
                SQ_IDLE: begin
                    if (hit[HIT_KEY1]) st_d.seq = SQ_K1;
                    else               to_plain = 1'b1;
                end
                SQ_K1: begin
                    if (hit[HIT_KEY2]) st_d.seq = SQ_K2;
                    else               to_plain = 1'b1;
                end
                SQ_K2: begin
                    if (hit[HIT_ARM]) begin
                        st_d.seq  = SQ_OPEN;
                        st_d.pend = PD_SET;
                    end else if (hit[HIT_OFF1]) begin
                        st_d.seq  = SQ_R3;
                    end else begin
                        to_plain  = 1'b1;
                    end
                end
                SQ_R3: begin
                    if (hit[HIT_KEY1]) st_d.seq = SQ_R4;
                    else               to_plain = 1'b1;
                end
                SQ_R4: begin
                    if (hit[HIT_KEY2]) st_d.seq = SQ_R5;
                    else               to_plain = 1'b1;
                end
                SQ_R5: begin
                    if (hit[HIT_OFF2]) begin
                        st_d.seq  = SQ_OPEN;
                        st_d.pend = PD_CLR;
                    end else begin
                        to_plain  = 1'b1;
                    end
                end
                SQ_OPEN, SQ_PLAIN: fwd = 1'b1;
                default:           fwd = 1'b0;   // SQ_LOCKED drops bytes
            endcase

            if (to_plain) begin
                if (st_q.prot) begin
                    st_d.seq = SQ_LOCKED;
                end else begin
                    st_d.seq = SQ_PLAIN;
                    fwd      = 1'b1;
                end
            end

            if (fwd) begin
                st_d.pass_vld  = 1'b1;
                st_d.pass_addr = wr_addr;
                st_d.pass_data = wr_data;
                st_d.passed    = 1'b1;
            end
        end

        // Close the load period and decide on a programming cycle.
        if (gap_end) begin
            st_d.prog_start = st_q.prot || st_q.passed || (st_q.pend != PD_NONE);
            st_d.seq        = SQ_IDLE;
            st_d.passed     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.seq  <= SQ_IDLE;
            st_q.pend <= PD_NONE;
            st_q.prot <= PROT_AT_RESET;
        end else begin
            st_q      <= st_d;
        end
    end

    assign pass_vld   = st_q.pass_vld;
    assign pass_addr  = st_q.pass_addr;
    assign pass_data  = st_q.pass_data;
    assign prog_start = st_q.prog_start;
    assign busy       = wc_busy;
    assign prot       = st_q.prot;

endmodule

// File: rtl/wp_seq_guard_chk.sv
module wp_seq_guard_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              pass_vld,
    input logic [ADDR_W-1:0] pass_addr,
    input logic [DATA_W-1:0] pass_data,
    input logic              prog_start,
    input logic              busy,
    input logic              prot
);

    a_r2_pass_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pass_vld |-> $past(wr_stb));

    a_r2_pass_copies_byte: assert property (@(posedge clk) disable iff (!rst_n)
        pass_vld |-> (pass_addr == $past(wr_addr) && pass_data == $past(wr_data)));

    a_r2_prog_opens_busy: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> $rose(busy));

    a_r2_prog_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);

    a_r9_no_pass_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pass_vld |-> !busy);

    a_r9_busy_strobe_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb) |=> !pass_vld);

    a_r11_prot_moves_at_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        (prot != $past(prot)) |-> $fell(busy));

endmodule

bind wp_seq_guard wp_seq_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pass_vld   (pass_vld),
    .pass_addr  (pass_addr),
    .pass_data  (pass_data),
    .prog_start (prog_start),
    .busy       (busy),
    .prot       (prot)
);

// File: tb/test_wp_seq_guard.sv
module test_wp_seq_guard;

    localparam int AW  = 15;
    localparam int DW  = 8;
    localparam int BLC = 8;
    localparam int WC  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic          wr_stb2 = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          pass_vld, prog_start, busy, prot;
    logic [AW-1:0] pass_addr;
    logic [DW-1:0] pass_data;
    logic          pass_vld2, prog_start2, busy2, prot2;
    logic [AW-1:0] pass_addr2;
    logic [DW-1:0] pass_data2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [AW+DW-1:0] exp_q[$];

    always #5 clk = ~clk;

    wp_seq_guard #(.ADDR_W(AW), .DATA_W(DW), .BLC_CYCLES(BLC), .WC_CYCLES(WC))
    i_wp_seq_guard (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .pass_vld(pass_vld), .pass_addr(pass_addr), .pass_data(pass_data),
        .prog_start(prog_start), .busy(busy), .prot(prot)
    );

    wp_seq_guard #(.ADDR_W(AW), .DATA_W(DW), .BLC_CYCLES(BLC), .WC_CYCLES(WC),
                   .PROT_AT_RESET(1'b1))
    i_wp_seq_guard_ret (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb2), .wr_addr(wr_addr), .wr_data(wr_data),
        .pass_vld(pass_vld2), .pass_addr(pass_addr2), .pass_data(pass_data2),
        .prog_start(prog_start2), .busy(busy2), .prot(prot2)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: every forwarded byte is popped from the scoreboard.
    always @(negedge clk) begin
        if (rst_n && pass_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R7 unexpected forward", int'({pass_addr, pass_data}), 0);
            end else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                chk({pass_addr, pass_data} == e, "R2 forwarded byte",
                    int'({pass_addr, pass_data}), int'(e));
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit exp_pass);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        if (exp_pass) exp_q.push_back({a, d});
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic finish_load(input bit exp_prog, input bit exp_prot, input bit poke,
                               input string req);
        int  np = 0;
        int  nb = 0;
        bit  p0 = prot;
        for (int i = 0; i < BLC + WC + 6; i++) begin
            @(negedge clk);
            if (prog_start) np++;
            if (busy) begin
                nb++;
                if (prot != p0) chk(1'b0, "R11 prot moved while busy", prot, p0);
            end
            if (poke && busy && nb == 3) begin
                wr_stb  = 1'b1;
                wr_addr = 15'h0042;
                wr_data = 8'h99;
            end else begin
                wr_stb  = 1'b0;
            end
        end
        chk(np == int'(exp_prog), {req, " prog_start count"}, np, int'(exp_prog));
        chk(nb == (exp_prog ? WC : 0), {req, " busy length"}, nb, exp_prog ? WC : 0);
        chk(prot == exp_prot, {req, " prot after cycle"}, prot, exp_prot);
        chk(exp_q.size() == 0, {req, " bytes missing"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic arm_code(input bit pass);
        wr(15'h5555, 8'hAA, pass);
        wr(15'h2AAA, 8'h55, pass);
        wr(15'h5555, 8'hA0, pass);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(prot == 1'b0 && busy == 1'b0, "R1 reset prot/busy", {prot, busy}, 0);
        chk(pass_vld == 1'b0 && prog_start == 1'b0, "R1 reset pass/prog",
            {pass_vld, prog_start}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(prot2 == 1'b1, "R11 preset instance starts protected", prot2, 1);

        // R2: plain unprotected load
        wr(15'h0010, 8'h01, 1'b1);
        wr(15'h0011, 8'h02, 1'b1);
        wr(15'h0013, 8'h03, 1'b1);
        finish_load(1'b1, 1'b0, 1'b0, "R2 plain load");

        // R10: command address holds ordinary data later in a load
        wr(15'h0000, 8'h11, 1'b1);
        wr(15'h5555, 8'hAA, 1'b1);
        wr(15'h2AAA, 8'h55, 1'b1);
        finish_load(1'b1, 1'b0, 1'b0, "R10 command address as data");

        // R8: gap aborts a code; nothing forwarded so no cycle
        wr(15'h5555, 8'hAA, 1'b0);
        finish_load(1'b0, 1'b0, 1'b0, "R8 aborted code");
        wr(15'h2AAA, 8'h55, 1'b1);
        finish_load(1'b1, 1'b0, 1'b0, "R8 fresh load after abort");

        // R7: mismatch mid-code, unprotected
        wr(15'h5555, 8'hAA, 1'b0);
        wr(15'h2AAA, 8'h55, 1'b0);
        wr(15'h1234, 8'h33, 1'b1);
        wr(15'h1235, 8'h44, 1'b1);
        finish_load(1'b1, 1'b0, 1'b0, "R7 mismatch unprotected");

        // R3: arming code alone sets protection
        arm_code(1'b0);
        finish_load(1'b1, 1'b1, 1'b0, "R3 arm without data");

        // R5: protected write without prefix
        wr(15'h0100, 8'h77, 1'b0);
        wr(15'h0101, 8'h78, 1'b0);
        finish_load(1'b1, 1'b1, 1'b0, "R5 unprefixed protected");

        // R6 + R9: prefixed protected write, strobe during busy ignored
        arm_code(1'b0);
        wr(15'h0200, 8'h5A, 1'b1);
        wr(15'h0203, 8'hC3, 1'b1);
        finish_load(1'b1, 1'b1, 1'b1, "R6/R9 prefixed write with busy strobe");

        // R7: mismatch mid-code, protected
        wr(15'h5555, 8'hAA, 1'b0);
        wr(15'h0000, 8'h12, 1'b0);
        wr(15'h0001, 8'h13, 1'b0);
        finish_load(1'b1, 1'b1, 1'b0, "R7 mismatch protected");

        // R4: release code followed by data
        wr(15'h5555, 8'hAA, 1'b0);
        wr(15'h2AAA, 8'h55, 1'b0);
        wr(15'h5555, 8'h80, 1'b0);
        wr(15'h5555, 8'hAA, 1'b0);
        wr(15'h2AAA, 8'h55, 1'b0);
        wr(15'h5555, 8'h20, 1'b0);
        wr(15'h0300, 8'hE7, 1'b1);
        finish_load(1'b1, 1'b0, 1'b0, "R4 release code");
        wr(15'h0301, 8'h6B, 1'b1);
        finish_load(1'b1, 1'b0, 1'b0, "R4 plain write after release");

        // R11/R5: preset-protected instance drops an unprefixed byte
        begin
            int nb2 = 0;
            int np2 = 0;
            @(negedge clk);
            wr_stb2 = 1'b1;
            wr_addr = 15'h0400;
            wr_data = 8'h21;
            for (int i = 0; i < BLC + WC + 6; i++) begin
                @(negedge clk);
                wr_stb2 = 1'b0;
                if (busy2) nb2++;
                if (pass_vld2) np2++;
            end
            chk(np2 == 0, "R11 preset instance forwarded", np2, 0);
            chk(nb2 == WC, "R11 preset instance busy length", nb2, WC);
            chk(prot2 == 1'b1, "R11 preset instance stays protected", prot2, 1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule